// File: doc/BRIEF.md
# Walsh Function Wave Generator

This block emits every Walsh function of a chosen order as parallel bit-streams, one new bit per function on every clock. Its state is a free-running down counter of ORDER flip-flops. The complement of that counter gives the current phase. Each output line is a fixed parity over selected phase bits, taken by an XOR network. Over one period of 2^ORDER clocks, the output bus steps through the columns of a Sylvester-ordered Hadamard matrix. Bit k of the bus traces row k of that matrix.

A synchronous seed load puts the counter at any phase, so a pattern generator can be reseeded mid-run. A logic 1 on an output encodes a +1 matrix entry and a logic 0 encodes -1. The output bus is registered.

Top module: `walsh_wave_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the whole output bus becomes all ones, which is phase 0.
- R2: Output bit 0 is 1 in every cycle.
- R3: After reset with no load, the phase in the j-th cycle is j mod 2^ORDER. Bit k of the bus is 1 exactly when popcount(k AND phase) is even.
- R4: The bus repeats with period 2^ORDER clocks. Phase 2^ORDER-1 is followed by phase 0.
- R5: For each counter bit i, output bit 2^i is the inverse of phase bit i. Output bit 1 toggles on every stepping clock.
- R6: When `load_en` is high at an edge, the phase in the next cycle is the bitwise complement of `load_seed`. Counting resumes from that phase.
- R7: `rst` takes priority over `load_en` when both are high.
- R8: Over any full period, any two distinct outputs agree in exactly 2^(ORDER-1) cycles, so they are mutually orthogonal.
- R9: Over any full period, every output other than bit 0 is 1 in exactly 2^(ORDER-1) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Load the seed into the counter at this edge |
| load_seed | input | ORDER | Counter seed; the resulting phase is its complement |
| walsh_o | output | 2^ORDER | Registered Walsh function bits, bit k is function k |

## Verification
Several properties are checked on every cycle by assertions:
- the constant-one row;
- the all-ones state after reset;
- the one-step decrement of the counter;
- the landing of a seed;
- reset priority;
- the tie between each single-bit-index output and its counter bit.

Other behaviour is shown only by the bench's scenarios. These are the full row pattern at every phase against an independently doubled Hadamard matrix, the wrap from the last phase back to phase 0, pairwise orthogonality and balance over a period, and continued counting after a reseed.

// File: rtl/walshgen_pkg.sv
package walshgen_pkg;
  // Next-state selection for the phase counter.
  typedef enum logic [1:0] {
    WG_HOLD_RESET = 2'd0,
    WG_LOAD       = 2'd1,
    WG_STEP       = 2'd2
  } wg_op_e;
endpackage

// File: rtl/wg_down_counter.sv
module wg_down_counter
  import walshgen_pkg::*;
#(
  parameter int ORDER = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic [ORDER-1:0] load_seed,
  output logic [ORDER-1:0] cnt_q,
  output logic [ORDER-1:0] cnt_d
);
  localparam logic [ORDER-1:0] CNT_ONE = ORDER'(1);

  wg_op_e op;

  always_comb begin
    if (rst)          op = WG_HOLD_RESET;
    else if (load_en) op = WG_LOAD;
    else              op = WG_STEP;
  end

  always_comb begin
    case (op)
      WG_HOLD_RESET: cnt_d = '1;
      WG_LOAD:       cnt_d = load_seed;
      default:       cnt_d = cnt_q - CNT_ONE;
    endcase
  end

  always_ff @(posedge clk) begin
    cnt_q <= cnt_d;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !load_en) |-> cnt_q == $past(cnt_q) - CNT_ONE); // R3
  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && load_en) |-> cnt_q == $past(load_seed)); // R6
  AST_RST_PRIO: assert property (@(posedge clk)
    $past(rst) |-> &cnt_q); // R7
endmodule

// File: rtl/wg_parity_net.sv
module wg_parity_net #(
  parameter int ORDER = 3,
  parameter int NFUNC = 1 << ORDER
) (
  input  logic [ORDER-1:0] cnt,
  output logic [NFUNC-1:0] rows
);
  logic [ORDER-1:0] phase;
  assign phase = ~cnt;

  for (genvar k = 0; k < NFUNC; k++) begin : g_row
    localparam logic [ORDER-1:0] SEL = ORDER'(k);
    // +1 entry (logic 1) when the selected phase bits have even parity
    assign rows[k] = ~(^(SEL & phase));
  end
endmodule

// File: rtl/walsh_wave_gen.sv
module walsh_wave_gen #(
  parameter int ORDER = 3,
  localparam int NFUNC = 1 << ORDER
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic [ORDER-1:0] load_seed,
  output logic [NFUNC-1:0] walsh_o
);
  logic [ORDER-1:0] cnt_q;
  logic [ORDER-1:0] cnt_d;
  logic [NFUNC-1:0] rows_d;

  wg_down_counter #(.ORDER(ORDER)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load_en  (load_en),
    .load_seed(load_seed),
    .cnt_q    (cnt_q),
    .cnt_d    (cnt_d)
  );

  // Rows are taken from the next counter value so that the
  // registered bus lines up with the counter state.
  wg_parity_net #(.ORDER(ORDER), .NFUNC(NFUNC)) u_par (
    .cnt (cnt_d),
    .rows(rows_d)
  );

  always_ff @(posedge clk) begin
    if (rst) walsh_o <= '1;
    else     walsh_o <= rows_d;
  end

  AST_RESET_ROW: assert property (@(posedge clk)
    $past(rst) |-> &walsh_o); // R1
  AST_ROW0_HIGH: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> walsh_o[0]); // R2
  AST_W1_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !load_en) |-> walsh_o[1] != $past(walsh_o[1])); // R5

  for (genvar i = 0; i < ORDER; i++) begin : g_chk
    localparam int IDX = 1 << i;
    AST_SINGLE_BIT: assert property (@(posedge clk) disable iff (rst)
      $past(!rst) |-> walsh_o[IDX] == cnt_q[i]); // R5
  end
endmodule

// File: tb/walsh_wave_gen_bench.sv
module walsh_wave_gen_bench;
  localparam int ORDER = 3;
  localparam int NF = 1 << ORDER;
  localparam int HALF = NF / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load_en = 1'b0;
  logic [ORDER-1:0] load_seed = '0;
  logic [NF-1:0] walsh_o;

  always #2 clk = ~clk; // 250 MHz

  walsh_wave_gen #(.ORDER(ORDER)) u_walsh_wave_gen (
    .clk(clk), .rst(rst), .load_en(load_en),
    .load_seed(load_seed), .walsh_o(walsh_o)
  );

  typedef struct {
    logic [NF-1:0] exp;
    string         req;
    bit            cap;
  } sb_item_t;

  sb_item_t sb_q[$];
  logic [NF-1:0] hist[$];
  logic hmat [NF][NF];
  int checks = 0;
  int fails = 0;
  int phase = 0;
  bit done = 1'b0;

  // Sylvester Hadamard matrix by recursive doubling, 1 encodes +1
  task automatic build_h();
    hmat[0][0] = 1'b1;
    for (int s = 1; s < NF; s = s * 2) begin
      for (int r = 0; r < s; r++) begin
        for (int c = 0; c < s; c++) begin
          hmat[r][c+s]   = hmat[r][c];
          hmat[r+s][c]   = hmat[r][c];
          hmat[r+s][c+s] = ~hmat[r][c];
        end
      end
    end
  endtask

  function automatic logic [NF-1:0] col_of(int p);
    logic [NF-1:0] v;
    for (int k = 0; k < NF; k++) v[k] = hmat[k][p];
    return v;
  endfunction

  task automatic check(bit ok, string req, logic [NF-1:0] act, logic [NF-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Driver: apply inputs for the next edge and push the expected bus
  task automatic drive_step(bit r, bit ld, logic [ORDER-1:0] seed, string req, bit cap);
    sb_item_t it;
    @(negedge clk);
    rst = r; load_en = ld; load_seed = seed;
    if (r)       phase = 0;
    else if (ld) phase = int'(~seed);
    else         phase = (phase + 1) % NF;
    it.exp = col_of(phase); it.req = req; it.cap = cap;
    sb_q.push_back(it);
  endtask

  // Monitor: pop and compare just after each edge
  initial begin
    sb_item_t it;
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        check(walsh_o == it.exp, it.req, walsh_o, it.exp);
        check(walsh_o[0] == 1'b1, "R2", {{(NF-1){1'b0}}, walsh_o[0]}, {{(NF-1){1'b0}}, 1'b1});
        if (it.cap) hist.push_back(walsh_o);
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int agree;
    int ones;
    build_h();
    drive_step(1, 0, '0, "R1", 0);
    drive_step(1, 0, '0, "R1", 0);
    drive_step(1, 1, 3'b010, "R7", 0);
    // two full periods of free running, captured for R4/R5/R8/R9
    for (int j = 0; j < 2 * NF; j++) drive_step(0, 0, '0, "R3", 1);
    // reseed mid-run, then keep counting
    drive_step(0, 1, 3'b101, "R6", 0);
    for (int j = 0; j < 5; j++) drive_step(0, 0, '0, "R6", 0);
    // seed all ones gives phase 0; seed zero gives last phase then wrap
    drive_step(0, 1, 3'b111, "R6", 0);
    drive_step(0, 1, 3'b000, "R6", 0);
    drive_step(0, 0, '0, "R4", 0);
    drive_step(0, 0, '0, "R4", 0);
    drive_step(1, 0, '0, "R1", 0);
    drive_step(0, 0, '0, "R3", 0);
    repeat (3) @(negedge clk);

    // R4: periodicity over the capture
    for (int j = 0; j < NF; j++)
      check(hist[j] == hist[j+NF], "R4", hist[j+NF], hist[j]);
    // R5: single-bit-index outputs; capture sample j has phase j+1
    for (int j = 0; j < NF; j++) begin
      for (int i = 0; i < ORDER; i++) begin
        logic e;
        e = ~1'(((j + 1) % NF) >> i);
        check(hist[j][1<<i] == e, "R5", NF'(hist[j][1<<i]), NF'(e));
      end
    end
    // R8: pairwise orthogonality; R9: balance
    for (int a = 0; a < NF; a++) begin
      ones = 0;
      for (int j = 0; j < NF; j++) ones += int'(hist[j][a]);
      if (a != 0) check(ones == HALF, "R9", NF'(ones), NF'(HALF));
      for (int b = a + 1; b < NF; b++) begin
        agree = 0;
        for (int j = 0; j < NF; j++) agree += int'(hist[j][a] == hist[j][b]);
        check(agree == HALF, "R8", NF'(agree), NF'(HALF));
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule